// File: doc/BRIEF.md
# Programmable Noise Channel

This block produces the noise voice of a sound generator. A 15-bit shift register with linear feedback supplies a pseudo-random bit. A reloading down-counter advances the register once per selected period. The period is counted in ticks of an input clock enable and is picked from one of two fixed 16-entry tables. A region input chooses the table, and a 4-bit index written to a control port chooses the entry.

The same control write also sets a mode flag that moves the feedback tap. With the flag clear the bit stream is the long maximal sequence. With it set the stream is one of two short loops. An external envelope supplies a 4-bit volume. The block passes that volume to its sample output, and mutes the output whenever the low register bit is one or an external length counter reports zero. A build parameter selects an early variant in which the mode flag has no effect.

Top module: `noise_channel`

## Requirements
- R1: After reset the shift register holds 1 and the timer count is zero. The sample is therefore 0, and the first enabled tick advances the register.
- R2: With the mode flag clear, one advance computes bit 0 XOR bit 1, then shifts the register right by one and places that value in bit 14.
- R3: With the mode flag set, the feedback is bit 0 XOR bit 6, and the register returns to its state at the mode change after 31 or 93 advances.
- R4: Starting from 1 with the mode flag clear, the register first returns to 1 after exactly 32767 advances.
- R5: When region_sel is 0, indices 0 to 15 select periods of 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034 and 4068 ticks.
- R6: When region_sel is 1, indices 0 to 15 select periods of 4, 8, 14, 30, 60, 88, 118, 148, 188, 236, 354, 472, 708, 944, 1890 and 3778 ticks.
- R7: The register advances on the tick at which the count is zero, which reloads the count to period minus one. Every other tick decrements the count. In a cycle without a tick, neither the count nor the register changes.
- R8: A new period index takes effect at the next reload and does not disturb the count in progress.
- R9: A write with wr_en high stores wr_data bit 7 as the mode flag and bits 3 to 0 as the period index. Bits 6 to 4 have no effect.
- R10: The sample equals volume unless bit 0 of the register is 1 or len_zero is high, in which case it is 0.
- R11: With IGNORE_MODE set to 1 the mode flag has no effect, and the feedback is always bit 0 XOR bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer clock enable, one tick per cycle high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control data: bit 7 mode flag, bits 3..0 period index |
| region_sel | input | 1 | Period table select: 0 table A, 1 table B |
| volume | input | VOL_W | Volume from the envelope |
| len_zero | input | 1 | Length counter has reached zero; mutes the output |
| sample | output | VOL_W | Gated 4-bit sample |

## Verification
The hardest condition to reach from the ports is the end of the long sequence. The register state is only visible through bit 0, and the wrap takes 32767 advances. The stimulus resets the block, holds tick_en high at the shortest period, and runs 131068 cycles. A reference model compares every output cycle on the way, and at the end the model must be back at 1 for the first time. The short-loop mode is entered from an arbitrary state reached after mixed periods, tick gaps and a mid-count index change. The bench checks the short loop length against its own model and the legacy instance in the same run.

// File: rtl/noise_pkg.sv
package noise_pkg;

  localparam int LFSR_W    = 15;
  localparam int PER_W     = 12;
  localparam int IDX_W     = 4;
  localparam int CTRL_W    = 8;
  localparam int MODE_BIT  = 7;
  localparam int TAP_LONG  = 1;
  localparam int TAP_SHORT = 6;

  // Timer period in ticks for a region and index.
  function automatic logic [PER_W-1:0] period_of(input logic region,
                                                 input logic [IDX_W-1:0] idx);
    logic [PER_W-1:0] p;
    if (!region) begin
      case (idx)
        4'd0:  p = 12'd4;
        4'd1:  p = 12'd8;
        4'd2:  p = 12'd16;
        4'd3:  p = 12'd32;
        4'd4:  p = 12'd64;
        4'd5:  p = 12'd96;
        4'd6:  p = 12'd128;
        4'd7:  p = 12'd160;
        4'd8:  p = 12'd202;
        4'd9:  p = 12'd254;
        4'd10: p = 12'd380;
        4'd11: p = 12'd508;
        4'd12: p = 12'd762;
        4'd13: p = 12'd1016;
        4'd14: p = 12'd2034;
        default: p = 12'd4068;
      endcase
    end else begin
      case (idx)
        4'd0:  p = 12'd4;
        4'd1:  p = 12'd8;
        4'd2:  p = 12'd14;
        4'd3:  p = 12'd30;
        4'd4:  p = 12'd60;
        4'd5:  p = 12'd88;
        4'd6:  p = 12'd118;
        4'd7:  p = 12'd148;
        4'd8:  p = 12'd188;
        4'd9:  p = 12'd236;
        4'd10: p = 12'd354;
        4'd11: p = 12'd472;
        4'd12: p = 12'd708;
        4'd13: p = 12'd944;
        4'd14: p = 12'd1890;
        default: p = 12'd3778;
      endcase
    end
    return p;
  endfunction

  // One advance: feedback from bit 0 and the chosen tap, shift right, insert at top.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s,
                                                     input logic short_mode);
    logic fb;
    fb = s[0] ^ (short_mode ? s[TAP_SHORT] : s[TAP_LONG]);
    return {fb, s[LFSR_W-1:1]};
  endfunction

endpackage

// File: rtl/noise_timer.sv
module noise_timer
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [PER_W-1:0] period,
  output logic             fire
);

  logic [PER_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign fire    = tick_en && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_en) begin
      if (at_zero) cnt <= period - PER_W'(1);
      else         cnt <= cnt - PER_W'(1);
    end
  end

  // R7: no tick, no movement of the count
  assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  // R8: the reload takes the period present at the reload edge
  assert_reload_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(period) - PER_W'(1)));

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_pkg::*;
#(
  parameter bit IGNORE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              mode,
  output logic [LFSR_W-1:0] state
);

  logic mode_eff;

  generate
    if (IGNORE_MODE) begin : g_legacy
      wire unused_mode = mode;
      assign mode_eff = 1'b0;
    end else begin : g_modal
      assign mode_eff = mode;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_W'(1);
    else if (step) state <= lfsr_advance(state, mode_eff);
  end

  // R2: a register seeded with 1 never reaches all zeros
  assert_never_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R2: the lower bits are the old upper bits after an advance
  assert_shift_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (state[LFSR_W-2:0] == $past(state[LFSR_W-1:1])));

  // R7: no advance without a timer event
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));

  generate
    if (IGNORE_MODE) begin : g_chk_legacy
      // R11: the legacy variant always uses the long tap
      assert_legacy_tap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state[LFSR_W-1] == ($past(state[0]) ^ $past(state[TAP_LONG]))));
    end else begin : g_chk_modal
      // R3: short mode feeds back bit 0 with bit 6
      assert_short_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode) |=> (state[LFSR_W-1] == ($past(state[0]) ^ $past(state[TAP_SHORT]))));
    end
  endgenerate

endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int VOL_W       = 4,
  parameter bit IGNORE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              region_sel,
  input  logic [VOL_W-1:0]  volume,
  input  logic              len_zero,
  output logic [VOL_W-1:0]  sample
);

  logic              mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PER_W-1:0]  period_sel;
  logic              shift_evt;
  logic [LFSR_W-1:0] lfsr_state;
  logic              muted;

  wire unused_ctrl = ^wr_data[MODE_BIT-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data[MODE_BIT];
      idx_q  <= wr_data[IDX_W-1:0];
    end
  end

  assign period_sel = period_of(region_sel, idx_q);

  noise_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .period  (period_sel),
    .fire    (shift_evt)
  );

  noise_lfsr #(.IGNORE_MODE(IGNORE_MODE)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (shift_evt),
    .mode  (mode_q),
    .state (lfsr_state)
  );

  assign muted  = lfsr_state[0] | len_zero;
  assign sample = muted ? '0 : volume;

  // R10: a nonzero sample means the channel is open and carries the volume
  assert_open_passes_volume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample != '0) |-> (!len_zero && !lfsr_state[0] && sample == volume));

  // R9: a write lands in the control state on the next cycle
  assert_write_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == $past(wr_data[MODE_BIT]) && idx_q == $past(wr_data[IDX_W-1:0])));

endmodule

// File: tb/noise_channel_bench.sv
module noise_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       region_sel = 1'b0;
  logic [3:0] volume = 4'd0;
  logic       len_zero = 1'b0;
  logic [3:0] sample;
  logic [3:0] sample_leg;

  always #4 clk = ~clk;

  noise_channel u_noise_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .region_sel(region_sel), .volume(volume), .len_zero(len_zero), .sample(sample)
  );

  noise_channel #(.IGNORE_MODE(1'b1)) u_legacy (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .region_sel(region_sel), .volume(volume), .len_zero(len_zero), .sample(sample_leg)
  );

  typedef struct {
    logic [3:0] e_main;
    logic [3:0] e_leg;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  int tab_a[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
  int tab_b[16] = '{4, 8, 14, 30, 60, 88, 118, 148, 188, 236, 354, 472, 708, 944, 1890, 3778};

  int unsigned m_s, l_s, bcnt, m_mode, m_idx, shifts;
  bit          early_return;

  function automatic int unsigned adv(input int unsigned s, input int tap);
    int unsigned fb;
    fb = (s ^ (s >> tap)) & 1;
    return (s >> 1) | (fb << 14);
  endfunction

  task automatic model_reset();
    m_s = 1; l_s = 1; bcnt = 0; m_mode = 0; m_idx = 0; shifts = 0; early_return = 0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Driver: applies one cycle of stimulus, advances the model, pushes the expectation.
  task automatic cyc(input bit tick, input logic [3:0] vol, input bit lz,
                     input bit wr, input logic [7:0] wd, input bit rsel, input string req);
    exp_t e;
    int   per;
    @(negedge clk);
    tick_en = tick; volume = vol; len_zero = lz; wr_en = wr; wr_data = wd; region_sel = rsel;
    @(posedge clk);
    if (tick) begin
      if (bcnt == 0) begin
        per  = rsel ? tab_b[m_idx] : tab_a[m_idx];
        bcnt = per - 1;
        m_s  = adv(m_s, (m_mode != 0) ? 6 : 1);
        l_s  = adv(l_s, 1);
        shifts++;
        if (m_s == 1 && shifts < 32767) early_return = 1;
      end else begin
        bcnt--;
      end
    end
    if (wr) begin
      m_mode = wd[7];
      m_idx  = wd[3:0];
    end
    e.e_main = ((m_s & 1) != 0 || lz) ? 4'd0 : vol;
    e.e_leg  = ((l_s & 1) != 0 || lz) ? 4'd0 : vol;
    e.req    = req;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_data = 0; region_sel = 0; len_zero = 0; volume = 4'd5;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Monitor: compares every produced sample with the queued expectation.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(sample == e.e_main, e.req, sample, e.e_main);
      check(sample_leg == e.e_leg, {e.req, "/R11"}, sample_leg, e.e_leg);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    report();
    $finish;
  end

  initial begin
    int unsigned snap, t;
    int k;
    do_reset();
    // R1: register holds 1, so the output is muted right after reset
    #1;
    check(sample == 4'd0, "R1", sample, 0);
    check(sample_leg == 4'd0, "R1", sample_leg, 0);
    // R1: the first tick advances the register at once, so the volume appears
    cyc(1, 4'd9, 0, 0, 8'h00, 0, "R1");
    // R7: no ticks, nothing moves
    for (int i = 0; i < 20; i++) cyc(0, 4'(i), 0, 0, 8'h00, 0, "R7");
    // R2, R5, R10: long mode, shortest period, changing volume and length flag
    for (int i = 0; i < 300; i++) cyc(1, 4'((i * 7) % 16), (i % 9) == 3, 0, 8'h00, 0, "R10");
    // R8, R9: index 2 with noise in bits 6..4 written mid-count
    cyc(1, 4'd11, 0, 1, 8'h72, 0, "R9");
    for (int i = 0; i < 400; i++) cyc(1, 4'd11, 0, 0, 8'h00, 0, "R8");
    // R5, R7: index 5 with ticks on every other cycle
    cyc(0, 4'd6, 0, 1, 8'h05, 0, "R9");
    for (int i = 0; i < 1500; i++) cyc(i % 2 == 0, 4'd6, 0, 0, 8'h00, 0, "R5");
    // R6: second table, index 2 and then 3
    cyc(1, 4'd13, 0, 1, 8'h02, 1, "R6");
    for (int i = 0; i < 600; i++) cyc(1, 4'd13, 0, 0, 8'h00, 1, "R6");
    cyc(1, 4'd13, 0, 1, 8'h03, 1, "R6");
    for (int i = 0; i < 900; i++) cyc(1, 4'd13, 0, 0, 8'h00, 1, "R6");
    // R3, R11: short mode at the shortest period
    cyc(1, 4'd15, 0, 1, 8'h80, 0, "R3");
    snap = m_s;
    t = snap;
    k = 0;
    for (int i = 1; i <= 93; i++) begin
      t = adv(t, 6);
      if (t == snap && k == 0) k = i;
    end
    check(k == 31 || k == 93, "R3", k, 93);
    for (int i = 0; i < 800; i++) cyc(1, 4'((i % 15) + 1), i % 13 == 5, 0, 8'h00, 0, "R3");
    // R4: full long sequence from reset
    do_reset();
    for (int i = 0; i < 131068; i++) cyc(1, 4'((i % 15) + 1), 0, 0, 8'h00, 0, "R4");
    check(m_s == 1 && shifts == 32767 && !early_return, "R4", int'(shifts), 32767);
    // R4: the register has wrapped to 1, so the output is muted again
    cyc(0, 4'd7, 0, 0, 8'h00, 0, "R4");
    repeat (3) @(posedge clk);
    report();
    $finish;
  end

endmodule